// File: doc/BRIEF.md
# Paged Card Address Decoder

This block turns a host address into the chip selects of a plug-in peripheral card. The card carries a boot ROM split into pages, a small buffer RAM split into pages, a register window for a floppy disk controller and a register window for a real-time clock. The decoder recognises the card's slice of the host address space, sorts each access into one of these targets, forms the physical ROM or RAM address from the page bits, and hands the register index to the controller or the clock.

The controller window is direction-dependent: reads and writes reach different register sets at different offsets. An enable bit lets the clock window take over the top 32 bytes of the card, which removes the controller window and pulls the end of the RAM down. An extra strobe marks the odd byte of the controller's data register, so that external wait-state logic can hold the host while the controller is not ready. All outputs are registered, one clock after the inputs.

Top module: `card_addr_decode`

## Requirements
- R1: In the standard host mode (`alt_host`=0) the card responds only when `(addr & 0x7E000) == 0x74000` and `card_on` is 1; otherwise every select and `wait_stb` is 0, `reg_idx` is 0 and both address outputs are 0.
- R2: In the alternate host mode (`alt_host`=1) the card region is `(addr & 0x1FE000) == 0x174000` instead.
- R3: Card offsets (`addr[12:0]`) below 0x1C00 select the ROM on reads only; `rom_addr` = `rom_page`*0x2000 + offset. A write there asserts no select.
- R4: Offsets 0x1C00–0x1FFF (offset bits 12..10 all 1) select the RAM on reads and writes unless R5–R8 claim the access; `ram_addr` = `ram_page`*0x400 + offset[9:0].
- R5: With `rtc_en`=0, a read at an even offset 0x1FF0–0x1FF6 asserts `fdc_cs` with `reg_idx` = offset[2:1] (0 status, 1 track, 2 sector, 3 data).
- R6: With `rtc_en`=0, a write at an even offset 0x1FF8–0x1FFE asserts `fdc_cs` with `reg_idx` = offset[2:1] (0 command, 1 track, 2 sector, 3 data).
- R7: With `rtc_en`=0, an access at offset 0x1FF7 (read) or 0x1FFF (write) asserts `wait_stb` but not `fdc_cs`.
- R8: With `rtc_en`=1, an even offset 0x1FE0–0x1FFE asserts `rtc_cs` in either direction with `reg_idx` = offset[4:1]; `fdc_cs` and `wait_stb` stay 0.
- R9: Within the last 1 KiB, every access not taken by `fdc_cs` or `rtc_cs` goes to RAM (odd bytes of both windows, writes into the controller read window); at most one select is 1.
- R10: Outputs change one clock after the inputs; during reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 21 | Host byte address |
| is_read | input | 1 | 1 for read, 0 for write |
| card_on | input | 1 | Card mapped into host space |
| rtc_en | input | 1 | Clock window replaces controller window |
| alt_host | input | 1 | Selects the alternate host region |
| rom_page | input | 2 | ROM page number |
| ram_page | input | 1 | RAM page number |
| rom_cs | output | 1 | ROM select |
| ram_cs | output | 1 | RAM select |
| fdc_cs | output | 1 | Floppy controller select |
| rtc_cs | output | 1 | Real-time clock select |
| wait_stb | output | 1 | Odd data-register byte strobe |
| reg_idx | output | 4 | Register index for controller or clock |
| rom_addr | output | 15 | Physical ROM address |
| ram_addr | output | 11 | Physical RAM address |

## Verification
The bench builds the block with its defaults: a 21-bit address, 13-bit card offset, two ROM page bits and one RAM page bit. The 21-bit width brings both host-mode regions and the address bits that the standard mask ignores within reach, and the page widths let every ROM and RAM page be exercised. Directed accesses walk every register offset of both windows in both directions and with the clock on and off, and a long biased random run compares each clock against a behavioural model.

// File: rtl/card_dec_pkg.sv
package card_dec_pkg;
  typedef struct packed {
    logic rom;
    logic ram;
    logic fdc;
    logic rtc;
    logic wstb;
  } sel_t;
endpackage

// File: rtl/card_region_match.sv
module card_region_match #(
  parameter int          ADDR_W = 21,
  parameter logic [20:0] MASK   = 21'h07E000,
  parameter logic [20:0] MATCH  = 21'h074000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  always_comb hit = ((addr & MASK[ADDR_W-1:0]) == MATCH[ADDR_W-1:0]);
endmodule

// File: rtl/card_window_decode.sv
module card_window_decode
  import card_dec_pkg::*;
#(
  parameter int OFF_W = 13,
  parameter int IDX_W = 4
) (
  input  logic [OFF_W-1:0] off,
  input  logic             active,
  input  logic             is_read,
  input  logic             rtc_en,
  output sel_t             sel,
  output logic [IDX_W-1:0] idx
);
  localparam int TAG_W   = OFF_W - 3;
  localparam int CLK_W   = OFF_W - 5;
  localparam logic [TAG_W-1:0] FDC_WR_TAG = '1;
  localparam logic [TAG_W-1:0] FDC_RD_TAG = FDC_WR_TAG - 1'b1;
  localparam logic [CLK_W-1:0] CLK_TAG    = '1;

  logic last_k, fdc_win, clk_win, fdc_hit, clk_hit;

  always_comb begin
    last_k  = &off[OFF_W-1:OFF_W-3];
    fdc_win = active && !rtc_en &&
              (off[OFF_W-1:3] == (is_read ? FDC_RD_TAG : FDC_WR_TAG));
    clk_win = active && rtc_en && (off[OFF_W-1:5] == CLK_TAG);
    fdc_hit = fdc_win && !off[0];
    clk_hit = clk_win && !off[0];

    sel.fdc  = fdc_hit;
    sel.rtc  = clk_hit;
    sel.wstb = fdc_win && (off[2:0] == 3'b111);
    sel.ram  = active && last_k && !fdc_hit && !clk_hit;
    sel.rom  = active && !last_k && is_read;

    if (fdc_hit)      idx = {{(IDX_W-2){1'b0}}, off[2:1]};
    else if (clk_hit) idx = off[4:1];
    else              idx = '0;
  end
endmodule

// File: rtl/card_addr_form.sv
module card_addr_form #(
  parameter int OFF_W    = 13,
  parameter int ROM_PG_W = 2,
  parameter int RAM_PG_W = 1
) (
  input  logic [OFF_W-1:0]           off,
  input  logic                       rom_sel,
  input  logic                       ram_sel,
  input  logic [ROM_PG_W-1:0]        rom_page,
  input  logic [RAM_PG_W-1:0]        ram_page,
  output logic [ROM_PG_W+OFF_W-1:0]  rom_a,
  output logic [RAM_PG_W+OFF_W-4:0]  ram_a
);
  localparam int RAM_OFF_W = OFF_W - 3;

  always_comb begin
    rom_a = rom_sel ? {rom_page, off} : '0;
    ram_a = ram_sel ? {ram_page, off[RAM_OFF_W-1:0]} : '0;
  end
endmodule

// File: rtl/card_addr_decode.sv
module card_addr_decode
  import card_dec_pkg::*;
#(
  parameter int          ADDR_W    = 21,
  parameter int          OFF_W     = 13,
  parameter int          ROM_PG_W  = 2,
  parameter int          RAM_PG_W  = 1,
  parameter int          IDX_W     = 4,
  parameter logic [20:0] STD_MASK  = 21'h07E000,
  parameter logic [20:0] STD_MATCH = 21'h074000,
  parameter logic [20:0] ALT_MASK  = 21'h1FE000,
  parameter logic [20:0] ALT_MATCH = 21'h174000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      is_read,
  input  logic                      card_on,
  input  logic                      rtc_en,
  input  logic                      alt_host,
  input  logic [ROM_PG_W-1:0]       rom_page,
  input  logic [RAM_PG_W-1:0]       ram_page,
  output logic                      rom_cs,
  output logic                      ram_cs,
  output logic                      fdc_cs,
  output logic                      rtc_cs,
  output logic                      wait_stb,
  output logic [IDX_W-1:0]          reg_idx,
  output logic [ROM_PG_W+OFF_W-1:0] rom_addr,
  output logic [RAM_PG_W+OFF_W-4:0] ram_addr
);
  localparam int N_MODES = 2;
  localparam int ROM_A_W = ROM_PG_W + OFF_W;
  localparam int RAM_A_W = RAM_PG_W + OFF_W - 3;

  logic [N_MODES-1:0] mode_hit;
  logic               active;
  sel_t               sel_d;
  logic [IDX_W-1:0]   idx_d;
  logic [ROM_A_W-1:0] rom_a_d;
  logic [RAM_A_W-1:0] ram_a_d;

  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    card_region_match #(
      .ADDR_W (ADDR_W),
      .MASK   ((m == 0) ? STD_MASK  : ALT_MASK),
      .MATCH  ((m == 0) ? STD_MATCH : ALT_MATCH)
    ) u_match (
      .addr (addr),
      .hit  (mode_hit[m])
    );
  end

  always_comb active = mode_hit[alt_host] && card_on;

  card_window_decode #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_win (
    .off     (addr[OFF_W-1:0]),
    .active  (active),
    .is_read (is_read),
    .rtc_en  (rtc_en),
    .sel     (sel_d),
    .idx     (idx_d)
  );

  card_addr_form #(.OFF_W(OFF_W), .ROM_PG_W(ROM_PG_W), .RAM_PG_W(RAM_PG_W)) u_form (
    .off      (addr[OFF_W-1:0]),
    .rom_sel  (sel_d.rom),
    .ram_sel  (sel_d.ram),
    .rom_page (rom_page),
    .ram_page (ram_page),
    .rom_a    (rom_a_d),
    .ram_a    (ram_a_d)
  );

  // Output register stage: next-state above, storage here.
  sel_t               sel_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ROM_A_W-1:0] rom_a_q;
  logic [RAM_A_W-1:0] ram_a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      idx_q   <= '0;
      rom_a_q <= '0;
      ram_a_q <= '0;
    end else begin
      sel_q   <= sel_d;
      idx_q   <= idx_d;
      rom_a_q <= rom_a_d;
      ram_a_q <= ram_a_d;
    end
  end

  always_comb begin
    rom_cs   = sel_q.rom;
    ram_cs   = sel_q.ram;
    fdc_cs   = sel_q.fdc;
    rtc_cs   = sel_q.rtc;
    wait_stb = sel_q.wstb;
    reg_idx  = idx_q;
    rom_addr = rom_a_q;
    ram_addr = ram_a_q;
  end

  // R9
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs, fdc_cs, rtc_cs}));

  // R3
  rom_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_cs) |-> $past(is_read));

  // R7
  odd_byte_no_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_stb |-> !fdc_cs);

  // R8
  clock_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_cs) |-> $past(rtc_en));

  // R8
  fdc_masked_by_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fdc_cs) |-> !$past(rtc_en));

  // R1
  card_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ram_cs) || $rose(rom_cs)) |-> $past(card_on));
endmodule

// File: tb/card_addr_decode_test.sv
`timescale 1ns/1ps
module card_addr_decode_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [20:0] addr;
  logic        is_read, card_on, rtc_en, alt_host;
  logic [1:0]  rom_page;
  logic        ram_page;
  logic        rom_cs, ram_cs, fdc_cs, rtc_cs, wait_stb;
  logic [3:0]  reg_idx;
  logic [14:0] rom_addr;
  logic [10:0] ram_addr;

  always #4 clk = ~clk;

  card_addr_decode uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .is_read(is_read), .card_on(card_on),
    .rtc_en(rtc_en), .alt_host(alt_host), .rom_page(rom_page), .ram_page(ram_page),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .fdc_cs(fdc_cs), .rtc_cs(rtc_cs),
    .wait_stb(wait_stb), .reg_idx(reg_idx), .rom_addr(rom_addr), .ram_addr(ram_addr)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [34:0] model(int a, bit rd, bit on, bit rtc, bit alt,
                                        int rp, int mp, output string tag);
    int  off = a & 'h1FFF;
    bit  hit = alt ? ((a & 'h1FE000) == 'h174000) : ((a & 'h7E000) == 'h74000);
    bit  act = hit && on;
    bit  last = off >= 'h1C00;
    bit  fw, f, ws, r, ram, rom;
    int  idx, ra, ma;
    fw  = act && !rtc && (rd ? (off >= 'h1FF0 && off <= 'h1FF7) : off >= 'h1FF8);
    f   = fw && (off % 2 == 0);
    ws  = fw && (off % 8 == 7);
    r   = act && rtc && off >= 'h1FE0 && (off % 2 == 0);
    ram = act && last && !f && !r;
    rom = act && !last && rd;
    idx = f ? (off / 2) % 4 : (r ? (off % 32) / 2 : 0);
    ra  = rom ? rp * 8192 + off : 0;
    ma  = ram ? mp * 1024 + off % 1024 : 0;
    if (!act)      tag = alt ? "R2" : "R1";
    else if (ws)   tag = "R7";
    else if (f)    tag = rd ? "R5" : "R6";
    else if (r)    tag = "R8";
    else if (ram)  tag = (off >= 'h1FE0) ? "R9" : "R4";
    else           tag = "R3";
    return {rom, ram, f, r, ws, idx[3:0], ra[14:0], ma[10:0]};
  endfunction

  function automatic logic [34:0] observed();
    return {rom_cs, ram_cs, fdc_cs, rtc_cs, wait_stb, reg_idx, rom_addr, ram_addr};
  endfunction

  task automatic compare(logic [34:0] exp, string tag);
    checks++;
    if (observed() !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, observed(), exp);
    end
  endtask

  // Drive one access at a falling edge; the previous one is checked first (R10 latency).
  task automatic access(int a, bit rd, bit on, bit rtc, bit alt, int rp, int mp);
    string t;
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    addr = a[20:0]; is_read = rd; card_on = on; rtc_en = rtc; alt_host = alt;
    rom_page = rp[1:0]; ram_page = mp[0];
    exp_q.push_back(model(a, rd, on, rtc, alt, rp, mp, t));
    tag_q.push_back(t);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    addr = 21'h075000; is_read = 1'b1; card_on = 1'b1; rtc_en = 1'b0;
    alt_host = 1'b0; rom_page = 2'd1; ram_page = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset holds outputs at zero even with an active access applied
    compare('0, "R10");
    rst_n = 1'b1;
    @(negedge clk);
    // R10: first registered value appears one clock after release
    begin
      string t;
      compare(model('h075000, 1, 1, 0, 0, 1, 0, t), "R10");
    end

    // R1: card off, region miss
    access('h074010, 1, 0, 0, 0, 0, 0);
    access('h076010, 1, 1, 0, 0, 0, 0);
    access('h1F4010, 1, 1, 0, 0, 2, 0);
    // R2: alternate host region
    access('h174020, 1, 1, 0, 1, 3, 0);
    access('h074020, 1, 1, 0, 1, 3, 0);
    access('h175FF0, 1, 1, 0, 1, 0, 0);
    // R3: ROM pages, write ignored
    for (int p = 0; p < 4; p++) access('h074000 + 'h1BFF - p, 1, 1, 0, 0, p, 0);
    access('h074100, 0, 1, 0, 0, 2, 0);
    // R4: RAM pages, both directions
    access('h075C00, 0, 1, 0, 0, 0, 1);
    access('h075EEF, 1, 1, 0, 0, 0, 1);
    access('h075FDF, 1, 1, 1, 0, 0, 0);
    // R5, R6, R7, R9: every byte of the controller window both directions
    for (int o = 'h1FF0; o <= 'h1FFF; o++) begin
      access('h074000 + o, 1, 1, 0, 0, 0, 1);
      access('h074000 + o, 0, 1, 0, 0, 0, 0);
    end
    // R8: clock window both directions
    for (int o = 'h1FE0; o <= 'h1FFF; o++) access('h074000 + o, o % 3 == 0, 1, 1, 0, 0, 1);

    // Biased random run against the model
    for (int i = 0; i < 3000; i++) begin
      int base, a;
      case ($urandom % 4)
        0: base = 'h074000;
        1: base = 'h174000;
        2: base = 'h1F4000;
        default: base = ($urandom % 'h200000) & 'h1FE000;
      endcase
      if ($urandom % 2) a = base + 'h1F00 + $urandom % 256;
      else              a = base + $urandom % 8192;
      access(a, $urandom % 2, ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
             $urandom % 4, $urandom % 2);
    end
    access(0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule